// File: doc/BRIEF.md
# Header Pin Multiplexer with GPIO Fallback

This block sits between eight expansion-header pads and the host's serial peripherals. Every pin either carries one fixed peripheral line (I2C clock or data, SPI chip select, MOSI, MISO or clock, UART transmit or receive) or becomes a plain software GPIO. The choice is made per pin in two steps. A select bit picks peripheral routing or GPIO. For GPIO pins, a direction bit then picks input or output, and an output-value bit gives the level driven.

The three control registers arrive as parallel ports, because the register-access protocol lies outside this block. A registered read value returns the synchronized level of every GPIO input pin. The pad side is an output-enable and output-data pair per pin, intended for a tristate buffer, plus the sampled pad level. The register values that hold after reset (select all ones, direction all ones) leave every pad undriven. An attached add-on board therefore sees no contention until software enables a pin.

Top module: `hdr_pinmux`

## Requirements
- R1: In the cycle after a synchronous reset, `pad_oe` and `pad_out` are all zero, `gpio_rd` is zero, and the four host return lines are 1.
- R2: The pin roles are fixed by bit position: 0 UART RX, 1 UART TX, 2 SPI clock, 3 SPI MISO, 4 SPI MOSI, 5 SPI chip select (active low), 6 I2C data, 7 I2C clock. A `gpio_sel` bit of 1 makes its pin a GPIO. A bit of 0 routes the pin to its role.
- R3: A pin with `gpio_sel`=1 and `gpio_dir`=0 is a GPIO output: `pad_oe`=1 and `pad_out` equals its `gpio_val` bit.
- R4: A pin with `gpio_sel`=1 and `gpio_dir`=1 is a GPIO input: `pad_oe`=0, and its `gpio_rd` bit shows the `pad_in` level three clock edges after the pad changes (two synchronizer flops, then the read register).
- R5: Bits of `gpio_rd` that belong to pins which are not GPIO inputs read 0.
- R6: In peripheral mode the SPI clock, MOSI, chip-select and UART TX pins are driven (`pad_oe`=1) with the matching host signal.
- R7: In peripheral mode the two I2C pins are open drain. `pad_out`=0, and `pad_oe` is 1 exactly when the host line is low. `host_scl_in`/`host_sda_in` return the pad level with the R4 latency.
- R8: In peripheral mode the MISO and RX pins are never driven. `host_miso`/`host_rx` return their pad level with the R4 latency.
- R9: A host return line whose pin is in GPIO mode idles at 1.
- R10: `pad_oe` and `pad_out` change on the clock edge after their control inputs change, never before. `pad_out` is 0 whenever `pad_oe` is 0.
- R11: A `gpio_val` bit has no effect on a pin that is not a GPIO output, and the host signals have no effect on GPIO pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_sel | input | 8 | Per pin: 1 GPIO, 0 peripheral |
| gpio_dir | input | 8 | Per GPIO pin: 1 input, 0 output |
| gpio_val | input | 8 | Level driven on GPIO outputs |
| gpio_rd | output | 8 | Synchronized level of GPIO input pins |
| pad_in | input | 8 | Sampled pad levels |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output data |
| host_scl_drv | input | 1 | Host I2C clock drive (0 pulls low) |
| host_sda_drv | input | 1 | Host I2C data drive (0 pulls low) |
| host_scl_in | output | 1 | Wired I2C clock level to host |
| host_sda_in | output | 1 | Wired I2C data level to host |
| host_sclk | input | 1 | Host SPI clock |
| host_mosi | input | 1 | Host SPI data out |
| host_cs_n | input | 1 | Host SPI chip select, active low |
| host_miso | output | 1 | SPI data back to host |
| host_tx | input | 1 | Host UART transmit |
| host_rx | output | 1 | UART receive back to host |

## Verification
A pin can change its mode in the same cycle that its pad level moves. The drive path, which switches on the next edge, and the return path, which lags by three edges, must then agree on the new mode. The bench provokes this with directed cases: in one negedge it moves the MISO pin between GPIO input and peripheral mode and also toggles its pad. It then checks `gpio_rd` and `host_miso` just before and just after the third edge, against the values the requirements predict for the new mode. Random rounds then change all registers, host lines and pads together. Each round is judged against bench functions once the outputs have settled.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int unsigned PIN_COUNT = 8;

  // Role value equals the pin's bit position.
  typedef enum logic [2:0] {
    ROLE_UART_RX = 3'd0,
    ROLE_UART_TX = 3'd1,
    ROLE_SPI_CLK = 3'd2,
    ROLE_SPI_MISO = 3'd3,
    ROLE_SPI_MOSI = 3'd4,
    ROLE_SPI_CSN = 3'd5,
    ROLE_I2C_DAT = 3'd6,
    ROLE_I2C_CLK = 3'd7
  } pin_role_e;

  typedef enum logic [1:0] {
    KIND_PUSH_OUT,
    KIND_OPEN_DRAIN,
    KIND_IN_ONLY
  } pin_kind_e;

  function automatic pin_role_e role_of(input int unsigned idx);
    return pin_role_e'(idx[2:0]);
  endfunction

  function automatic pin_kind_e kind_of(input pin_role_e r);
    case (r)
      ROLE_I2C_CLK, ROLE_I2C_DAT: return KIND_OPEN_DRAIN;
      ROLE_SPI_MISO, ROLE_UART_RX: return KIND_IN_ONLY;
      default: return KIND_PUSH_OUT;
    endcase
  endfunction
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[LAST];
endmodule

// File: rtl/pinmux_drive_cell.sv
module pinmux_drive_cell
  import pinmux_pkg::*;
#(
  parameter pin_role_e ROLE = ROLE_SPI_CLK
) (
  input  logic clk,
  input  logic rst,
  input  logic use_gpio,
  input  logic is_input,
  input  logic gpio_level,
  input  logic host_line,
  output logic oe,
  output logic dout
);
  localparam pin_kind_e KIND = kind_of(ROLE);

  logic periph_oe, periph_out;

  if (KIND == KIND_OPEN_DRAIN) begin : g_od
    assign periph_oe  = ~host_line;
    assign periph_out = 1'b0;
  end else if (KIND == KIND_IN_ONLY) begin : g_in
    assign periph_oe  = 1'b0;
    assign periph_out = 1'b0;
  end else begin : g_push
    assign periph_oe  = 1'b1;
    assign periph_out = host_line;
  end

  logic next_oe, next_out;
  always_comb begin
    if (use_gpio) begin
      next_oe  = ~is_input;
      next_out = ~is_input & gpio_level;
    end else begin
      next_oe  = periph_oe;
      next_out = periph_oe & periph_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      dout <= 1'b0;
    end else begin
      oe   <= next_oe;
      dout <= next_out;
    end
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  // R10: data stays low while the pad is released
  assert_quiet_data_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    !oe |-> !dout);

  // R3, R4: GPIO direction lands one edge later
  assert_gpio_dir_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(use_gpio) && !$past(rst) |-> (oe == !$past(is_input)));

  if (KIND == KIND_OPEN_DRAIN) begin : g_chk_od
    assert_open_drain_R7: assert property (@(posedge clk) disable iff (rst || !armed)
      !$past(use_gpio) && !$past(rst) |-> !dout && (oe == !$past(host_line)));
  end else if (KIND == KIND_IN_ONLY) begin : g_chk_in
    assert_in_role_R8: assert property (@(posedge clk) disable iff (rst || !armed)
      !$past(use_gpio) |-> !oe);
  end else begin : g_chk_push
    assert_out_role_R6: assert property (@(posedge clk) disable iff (rst || !armed)
      !$past(use_gpio) && !$past(rst) |-> oe && (dout == $past(host_line)));
  end
endmodule

// File: rtl/pinmux_return.sv
module pinmux_return
  import pinmux_pkg::*;
#(
  parameter int unsigned PINS = PIN_COUNT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] use_gpio,
  input  logic [PINS-1:0] is_input,
  input  logic [PINS-1:0] level,
  output logic [PINS-1:0] rd_val,
  output logic            scl_in,
  output logic            sda_in,
  output logic            miso,
  output logic            rx
);
  localparam int unsigned P_CLK = int'(ROLE_I2C_CLK);
  localparam int unsigned P_DAT = int'(ROLE_I2C_DAT);
  localparam int unsigned P_MISO = int'(ROLE_SPI_MISO);
  localparam int unsigned P_RX = int'(ROLE_UART_RX);

  logic [PINS-1:0] rd_mask;
  assign rd_mask = use_gpio & is_input;

  function automatic logic back(input logic gp, input logic lv);
    return gp ? 1'b1 : lv;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_val <= '0;
      scl_in <= 1'b1;
      sda_in <= 1'b1;
      miso   <= 1'b1;
      rx     <= 1'b1;
    end else begin
      rd_val <= rd_mask & level;
      scl_in <= back(use_gpio[P_CLK], level[P_CLK]);
      sda_in <= back(use_gpio[P_DAT], level[P_DAT]);
      miso   <= back(use_gpio[P_MISO], level[P_MISO]);
      rx     <= back(use_gpio[P_RX], level[P_RX]);
    end
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  // R5: read bits of non-input pins are zero
  assert_rd_mask_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (rd_val & ~$past(rd_mask)) == '0);

  // R9: idle-high returns for GPIO pins
  assert_idle_miso_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(use_gpio[P_MISO]) |-> miso);
  assert_idle_rx_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(use_gpio[P_RX]) |-> rx);
endmodule

// File: rtl/hdr_pinmux.sv
module hdr_pinmux
  import pinmux_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PIN_COUNT-1:0] gpio_sel,
  input  logic [PIN_COUNT-1:0] gpio_dir,
  input  logic [PIN_COUNT-1:0] gpio_val,
  output logic [PIN_COUNT-1:0] gpio_rd,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] pad_out,
  input  logic                 host_scl_drv,
  input  logic                 host_sda_drv,
  output logic                 host_scl_in,
  output logic                 host_sda_in,
  input  logic                 host_sclk,
  input  logic                 host_mosi,
  input  logic                 host_cs_n,
  output logic                 host_miso,
  input  logic                 host_tx,
  output logic                 host_rx
);
  // Host drive value presented to each pin's cell.
  logic [PIN_COUNT-1:0] host_drv;
  always_comb begin
    for (int i = 0; i < PIN_COUNT; i++) begin
      case (role_of(i))
        ROLE_I2C_CLK: host_drv[i] = host_scl_drv;
        ROLE_I2C_DAT: host_drv[i] = host_sda_drv;
        ROLE_SPI_CLK: host_drv[i] = host_sclk;
        ROLE_SPI_MOSI: host_drv[i] = host_mosi;
        ROLE_SPI_CSN: host_drv[i] = host_cs_n;
        ROLE_UART_TX: host_drv[i] = host_tx;
        default: host_drv[i] = 1'b1;
      endcase
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    pinmux_drive_cell #(.ROLE(role_of(p))) u_cell (
      .clk       (clk),
      .rst       (rst),
      .use_gpio  (gpio_sel[p]),
      .is_input  (gpio_dir[p]),
      .gpio_level(gpio_val[p]),
      .host_line (host_drv[p]),
      .oe        (pad_oe[p]),
      .dout      (pad_out[p])
    );
  end

  logic [PIN_COUNT-1:0] pad_sync;
  pinmux_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pad_in),
    .dout(pad_sync)
  );

  pinmux_return #(.PINS(PIN_COUNT)) u_ret (
    .clk     (clk),
    .rst     (rst),
    .use_gpio(gpio_sel),
    .is_input(gpio_dir),
    .level   (pad_sync),
    .rd_val  (gpio_rd),
    .scl_in  (host_scl_in),
    .sda_in  (host_sda_in),
    .miso    (host_miso),
    .rx      (host_rx)
  );

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  // R1: pads released right after reset
  assert_reset_safe_R1: assert property (@(posedge clk) disable iff (!armed)
    !rst && $past(rst) |-> (pad_oe == '0) && (pad_out == '0));

  // R11: GPIO pins ignore host lines
  assert_host_ignored_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(rst) |-> ((pad_out & $past(gpio_sel)) == ($past(gpio_sel & ~gpio_dir & gpio_val))));
endmodule

// File: tb/hdr_pinmux_test.sv
`timescale 1ns/1ps
module hdr_pinmux_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] sel = 8'hFF, dir = 8'hFF, val = 8'h00, pad = 8'h00;
  logic scl_d = 1'b1, sda_d = 1'b1, sclk = 1'b0, mosi = 1'b0, csn = 1'b1, tx = 1'b1;
  logic [7:0] rd, oe, po;
  logic scl_i, sda_i, miso, rx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdr_pinmux uut (
    .clk(clk), .rst(rst), .gpio_sel(sel), .gpio_dir(dir), .gpio_val(val),
    .gpio_rd(rd), .pad_in(pad), .pad_oe(oe), .pad_out(po),
    .host_scl_drv(scl_d), .host_sda_drv(sda_d), .host_scl_in(scl_i), .host_sda_in(sda_i),
    .host_sclk(sclk), .host_mosi(mosi), .host_cs_n(csn), .host_miso(miso),
    .host_tx(tx), .host_rx(rx)
  );

  // Expected values from the requirements (R2 bit positions).
  function automatic logic [7:0] exp_oe();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (sel[i]) r[i] = ~dir[i];
      else case (i)
        7: r[i] = ~scl_d;
        6: r[i] = ~sda_d;
        3, 0: r[i] = 1'b0;
        default: r[i] = 1'b1;
      endcase
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_out();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (sel[i]) r[i] = ~dir[i] & val[i];
      else case (i)
        5: r[i] = csn;
        4: r[i] = mosi;
        2: r[i] = sclk;
        1: r[i] = tx;
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_settled(input string tag);
    chk({tag, " R3 R6 R7 R8 pad_oe"}, oe, exp_oe());
    chk({tag, " R10 R11 pad_out"}, po, exp_out());
    chk({tag, " R4 R5 gpio_rd"}, rd, sel & dir & pad);
    chk({tag, " R7 R9 scl_in"}, {7'd0, scl_i}, {7'd0, sel[7] ? 1'b1 : pad[7]});
    chk({tag, " R7 R9 sda_in"}, {7'd0, sda_i}, {7'd0, sel[6] ? 1'b1 : pad[6]});
    chk({tag, " R8 R9 miso"}, {7'd0, miso}, {7'd0, sel[3] ? 1'b1 : pad[3]});
    chk({tag, " R8 R9 rx"}, {7'd0, rx}, {7'd0, sel[0] ? 1'b1 : pad[0]});
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    pad = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, host drive lines set so they would drive if routed
    chk("R1 pad_oe", oe, 8'h00);
    chk("R1 pad_out", po, 8'h00);
    chk("R1 gpio_rd", rd, 8'h00);
    chk("R1 returns", {4'd0, scl_i, sda_i, miso, rx}, 8'h0F);
    rst = 1'b0;
    settle();
    check_settled("R1 post-reset all-input");

    // R3 and R10: drive edge timing on pin 2
    val = 8'h04; dir = 8'hFB;
    #1 chk("R10 no early drive", oe, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R3 R10 oe one edge", oe, 8'h04);
    chk("R3 out one edge", po, 8'h04);

    // R11: val on input pins ignored
    val = 8'hFF;
    @(posedge clk); @(negedge clk);
    chk("R11 val ignored on inputs", po, 8'h04);

    // R4: three-edge read latency on pin 5
    sel = 8'hFF; dir = 8'hFF; pad = 8'h00;
    settle();
    pad = 8'h20;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R4 rd before third edge", rd, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R4 rd at third edge", rd, 8'h20);

    // R7: open-drain I2C
    sel = 8'h3F; scl_d = 1'b0; sda_d = 1'b1; pad = 8'h40;
    settle();
    check_settled("R7 i2c");
    chk("R7 od pins", {oe[7:6], po[7:6]}, {2'b10, 2'b00});

    // Concurrent mode change and pad toggle on MISO (pin 3)
    sel = 8'hFF; dir = 8'hFF; pad = 8'h00;
    settle();
    sel = 8'hF7; pad = 8'h08;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R8 miso before third edge", {7'd0, miso}, 8'h00);
    chk("R5 rd masked at once", rd & 8'h08, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R8 miso at third edge", {7'd0, miso}, 8'h01);
    sel = 8'hFF; pad = 8'h00;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R9 miso idles as GPIO", {7'd0, miso}, 8'h01);
    chk("R4 rd old level", rd & 8'h08, 8'h08);
    @(posedge clk); @(negedge clk);
    chk("R4 rd new level", rd & 8'h08, 8'h00);

    // R6: peripheral push lines, R2 positions
    sel = 8'h00; sclk = 1'b1; mosi = 1'b0; csn = 1'b0; tx = 1'b1;
    scl_d = 1'b1; sda_d = 1'b1;
    settle();
    check_settled("R2 R6 all peripheral");

    for (int n = 0; n < 300; n++) begin
      sel = 8'($urandom); dir = 8'($urandom); val = 8'($urandom); pad = 8'($urandom);
      {scl_d, sda_d, sclk, mosi, csn, tx} = 6'($urandom);
      settle();
      check_settled("random");
    end

    // R1: reset mid-run releases pads
    sel = 8'hFF; dir = 8'h00; val = 8'hFF;
    settle();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset release", oe, 8'h00);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule